// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers interrupt requests from on-chip peripherals, external interrupt pins and firmware, and selects one winner for the processor. Each hardware request line has a fixed level from 1 to 7 and a fixed slot from 0 to 8 within that level. The centre slot of every level is kept for that level's external pin. Each level also has one software interrupt, which firmware sets and clears through a small register port. A pending software interrupt takes part in arbitration at the centre slot of its level.

Arbitration is ranked in two steps. The highest active level wins. Within that level, the highest active slot wins. The winning level and a request flag go to the processor one clock after the inputs are sampled. When the processor acknowledges, the block captures the winner's vector number and its byte offset into the vector table. The captured pair stays unchanged until the next accepted acknowledge.

Top module: `intc_leveled`

## Requirements
- R1: While reset is asserted, and directly after it, `irq_level_o`, `irq_req_o`, `vec_num_o`, `vec_off_o` and `swi_pend_o` are all zero.
- R2: One clock after the inputs are sampled, `irq_level_o` shows the highest level that has an active source, and `irq_req_o` is high exactly when that level is nonzero. With no active source, the level is 0 and the request is low.
- R3: Within a level L (1..7), the highest active slot wins. Peripheral line `periph_req_i[8*(L-1)+j]` sits in slot j when j < 4 and in slot j+1 when j >= 4. `ext_irq_i[L-1]` sits in slot 4.
- R4: A hardware source at level L and slot s has vector 93 - (9*(L-1) + s). Hardware vectors therefore fill 31..93, with 93 at level 1 slot 0.
- R5: The software interrupt of level L has vector 96 + (7 - L), so level 7 uses 96 and level 1 uses 102.
- R6: `vec_off_o` always equals `vec_num_o` times 4.
- R7: When the external pin and the software interrupt of the same level are both active in slot 4, the external pin wins and its hardware vector is reported.
- R8: `swi_pend_o[L-1]` is set by a 1 on `swi_set_i[L-1]` and cleared by a 1 on `swi_clr_i[L-1]`, each taking effect at the next clock. A set wins over a clear in the same cycle. A pending bit stays set until it is cleared, and it enters arbitration one clock after it is set.
- R9: An acknowledge (`ack_i` high at a clock edge) while `irq_req_o` is high captures the vector and offset of the winner shown on `irq_level_o` at that edge. In every other cycle, including an acknowledge while `irq_req_o` is low, `vec_num_o` and `vec_off_o` hold their value.
- R10: Hardware lines are level-sensitive: a line that drops is excluded from the next arbitration result.
- R11: `vec_num_o` is only ever 0, a value in 31..93, or a value in 96..102. Vectors 94, 95 and 103 and above never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| periph_req_i | input | 56 | Peripheral request lines, eight per level |
| ext_irq_i | input | 7 | External pin requests, bit L-1 for level L, slot 4 |
| swi_set_i | input | 7 | Software interrupt set strobes, bit L-1 for level L |
| swi_clr_i | input | 7 | Software interrupt clear strobes, bit L-1 for level L |
| ack_i | input | 1 | Processor acknowledge, captures the winner's vector |
| irq_level_o | output | 3 | Winning level, 0 when nothing is pending |
| irq_req_o | output | 1 | Interrupt request to the processor |
| vec_num_o | output | 8 | Captured vector number |
| vec_off_o | output | 10 | Captured vector byte offset |
| swi_pend_o | output | 7 | Software interrupt pending bits |

## Verification
A wrong pending bit in the software register shows on `swi_pend_o` at the very next clock. It reaches `irq_level_o` one clock after that, whenever no higher level hides it. A slot or vector mapping error does not change the level at all. It only appears in `vec_num_o` after the next acknowledge, so the bench acknowledges often, at single-source and mixed-source points, to expose each mapping one capture later. A stale captured vector shows as a value that differs from the previous winner in the clock right after an acknowledge, or as a value that moves while no acknowledge is accepted.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LEVELS       = 7;
  localparam int SLOTS        = 9;
  localparam int MID_SLOT     = SLOTS / 2;
  localparam int PER_LVL      = SLOTS - 1;
  localparam int PERIPH_N     = LEVELS * PER_LVL;
  localparam int HW_N         = LEVELS * SLOTS;
  localparam int HW_VEC_LAST  = 93;
  localparam int HW_VEC_FIRST = HW_VEC_LAST - HW_N + 1;
  localparam int SWI_VEC_BASE = 96;
  localparam int SWI_VEC_LAST = SWI_VEC_BASE + LEVELS - 1;
  localparam int LVL_W        = $clog2(LEVELS + 1);
  localparam int VEC_W        = 8;
  localparam int OFF_W        = VEC_W + 2;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [OFF_W-1:0] off_t;

  typedef struct packed {
    logic valid;
    vec_t vec;
  } lvl_win_t;

  // hardware vectors count down from the top of the block as rank rises
  function automatic vec_t hw_vector(int lvl, int slot);
    return vec_t'(HW_VEC_LAST - ((lvl - 1) * SLOTS + slot));
  endfunction

  // software vectors: highest level takes the lowest number
  function automatic vec_t swi_vector(int lvl);
    return vec_t'(SWI_VEC_BASE + LEVELS - lvl);
  endfunction

  function automatic off_t vec_offset(vec_t v);
    return {v, 2'b00};
  endfunction

  // peripheral line j of a level skips the centre slot
  function automatic int periph_slot(int j);
    return (j < MID_SLOT) ? j : j + 1;
  endfunction
endpackage

// File: rtl/intc_swi_regs.sv
module intc_swi_regs
  import intc_pkg::*;
#(
  parameter int N = LEVELS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // set dominates clear when both arrive together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_level_arb.sv
module intc_level_arb
  import intc_pkg::*;
#(
  parameter int LVL = 1
) (
  input  logic [PER_LVL-1:0] periph_i,
  input  logic               ext_i,
  input  logic               swi_i,
  output lvl_win_t           win_o
);
  logic [SLOTS-1:0] slot_req;

  for (genvar j = 0; j < PER_LVL; j++) begin : g_map
    assign slot_req[periph_slot(j)] = periph_i[j];
  end
  assign slot_req[MID_SLOT] = ext_i | swi_i;

  // ascending scan: the last active slot seen is the highest one
  always_comb begin
    win_o = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_req[s]) begin
        win_o.valid = 1'b1;
        if (s == MID_SLOT && !ext_i) win_o.vec = swi_vector(LVL);
        else                         win_o.vec = hw_vector(LVL, s);
      end
    end
  end
endmodule

// File: rtl/intc_level_pick.sv
module intc_level_pick
  import intc_pkg::*;
(
  input  lvl_win_t [LEVELS-1:0] wins_i,
  output logic                  valid_o,
  output lvl_t                  level_o,
  output vec_t                  vec_o
);
  always_comb begin
    valid_o = 1'b0;
    level_o = '0;
    vec_o   = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (wins_i[l].valid) begin
        valid_o = 1'b1;
        level_o = lvl_t'(l + 1);
        vec_o   = wins_i[l].vec;
      end
    end
  end
endmodule

// File: rtl/intc_leveled.sv
module intc_leveled
  import intc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIPH_N-1:0] periph_req_i,
  input  logic [LEVELS-1:0]   ext_irq_i,
  input  logic [LEVELS-1:0]   swi_set_i,
  input  logic [LEVELS-1:0]   swi_clr_i,
  input  logic                ack_i,
  output logic [LVL_W-1:0]    irq_level_o,
  output logic                irq_req_o,
  output logic [VEC_W-1:0]    vec_num_o,
  output logic [OFF_W-1:0]    vec_off_o,
  output logic [LEVELS-1:0]   swi_pend_o
);
  logic [LEVELS-1:0]     swi_pend;
  lvl_win_t [LEVELS-1:0] lvl_wins;
  logic                  win_valid;
  lvl_t                  win_level;
  vec_t                  win_vec;
  logic                  ack_take;

  lvl_t cur_level_q;
  logic req_q;
  vec_t cur_vec_q;
  off_t cur_off_q;
  vec_t vec_q;
  off_t off_q;

  intc_swi_regs #(.N(LEVELS)) u_swi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (swi_set_i),
    .clr_i  (swi_clr_i),
    .pend_o (swi_pend)
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    intc_level_arb #(.LVL(l + 1)) u_arb (
      .periph_i (periph_req_i[l*PER_LVL +: PER_LVL]),
      .ext_i    (ext_irq_i[l]),
      .swi_i    (swi_pend[l]),
      .win_o    (lvl_wins[l])
    );
  end

  intc_level_pick u_pick (
    .wins_i  (lvl_wins),
    .valid_o (win_valid),
    .level_o (win_level),
    .vec_o   (win_vec)
  );

  assign ack_take = ack_i & req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_level_q <= '0;
      req_q       <= 1'b0;
      cur_vec_q   <= '0;
      cur_off_q   <= '0;
    end else begin
      cur_level_q <= win_level;
      req_q       <= win_valid;
      cur_vec_q   <= win_vec;
      cur_off_q   <= vec_offset(win_vec);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      off_q <= '0;
    end else if (ack_take) begin
      vec_q <= cur_vec_q;
      off_q <= cur_off_q;
    end
  end

  assign irq_level_o = cur_level_q;
  assign irq_req_o   = req_q;
  assign vec_num_o   = vec_q;
  assign vec_off_o   = off_q;
  assign swi_pend_o  = swi_pend;
endmodule

// File: rtl/intc_leveled_chk.sv
module intc_leveled_chk
  import intc_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [PERIPH_N-1:0] periph_req_i,
  input logic [LEVELS-1:0]   ext_irq_i,
  input logic [LEVELS-1:0]   swi_set_i,
  input logic [LEVELS-1:0]   swi_clr_i,
  input logic [LVL_W-1:0]    irq_level_o,
  input logic                irq_req_o,
  input logic [VEC_W-1:0]    vec_num_o,
  input logic [OFF_W-1:0]    vec_off_o,
  input logic [LEVELS-1:0]   swi_pend_o,
  input logic [VEC_W-1:0]    cur_vec_q,
  input logic                ack_take
);
  AST_REQ_IFF_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o == (irq_level_o != '0)); // R2

  AST_TOP_LEVEL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_irq_i[LEVELS-1] |=> irq_level_o == lvl_t'(LEVELS)); // R2

  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periph_req_i == '0 && ext_irq_i == '0 && swi_pend_o == '0) |=> !irq_req_o); // R10

  AST_OFF_TRACKS_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_off_o == {vec_num_o, 2'b00}); // R6

  AST_NO_RESERVED_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_num_o == '0) ||
    (vec_num_o >= vec_t'(HW_VEC_FIRST) && vec_num_o <= vec_t'(HW_VEC_LAST)) ||
    (vec_num_o >= vec_t'(SWI_VEC_BASE) && vec_num_o <= vec_t'(SWI_VEC_LAST))); // R11

  AST_ACK_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_take |=> vec_num_o == $past(cur_vec_q)); // R9

  AST_HOLD_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_take |=> $stable(vec_num_o) && $stable(vec_off_o)); // R9

  AST_SWI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swi_set_i != '0) |=> (swi_pend_o & $past(swi_set_i)) == $past(swi_set_i)); // R8

  AST_SWI_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((swi_clr_i & ~swi_set_i) != '0) |=> (swi_pend_o & $past(swi_clr_i & ~swi_set_i)) == '0); // R8
endmodule

bind intc_leveled intc_leveled_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .periph_req_i (periph_req_i),
  .ext_irq_i    (ext_irq_i),
  .swi_set_i    (swi_set_i),
  .swi_clr_i    (swi_clr_i),
  .irq_level_o  (irq_level_o),
  .irq_req_o    (irq_req_o),
  .vec_num_o    (vec_num_o),
  .vec_off_o    (vec_off_o),
  .swi_pend_o   (swi_pend_o),
  .cur_vec_q    (cur_vec_q),
  .ack_take     (ack_take)
);

// File: tb/test_intc_leveled.sv
module test_intc_leveled;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [55:0] periph_req_i = '0;
  logic [6:0]  ext_irq_i = '0;
  logic [6:0]  swi_set_i = '0;
  logic [6:0]  swi_clr_i = '0;
  logic        ack_i = 1'b0;
  logic [2:0]  irq_level_o;
  logic        irq_req_o;
  logic [7:0]  vec_num_o;
  logic [9:0]  vec_off_o;
  logic [6:0]  swi_pend_o;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  // behavioural model state
  logic [6:0] m_pend;
  int m_lvl, m_vec, m_cap;
  bit m_req;

  intc_leveled i_intc_leveled (
    .clk_i(clk_i), .rst_ni(rst_ni), .periph_req_i(periph_req_i),
    .ext_irq_i(ext_irq_i), .swi_set_i(swi_set_i), .swi_clr_i(swi_clr_i),
    .ack_i(ack_i), .irq_level_o(irq_level_o), .irq_req_o(irq_req_o),
    .vec_num_o(vec_num_o), .vec_off_o(vec_off_o), .swi_pend_o(swi_pend_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // sources listed flat: 0..55 peripherals, 56..62 pins, 63..69 software.
  // A later source replaces the best only with a strictly higher rank.
  function automatic void model_arb(input logic [55:0] p, input logic [6:0] e,
                                    input logic [6:0] s, output int lvl, output int vec);
    int best;
    best = -1; lvl = 0; vec = 0;
    for (int idx = 0; idx < 70; idx++) begin
      int l, sl, v, rank;
      bit act;
      if (idx < 56) begin
        l = idx / 8 + 1; sl = idx % 8; if (sl >= 4) sl = sl + 1;
        act = p[idx]; v = 93 - (9 * (l - 1) + sl);
      end else if (idx < 63) begin
        l = idx - 55; sl = 4; act = e[l-1]; v = 93 - (9 * (l - 1) + 4);
      end else begin
        l = idx - 62; sl = 4; act = s[l-1]; v = 96 + 7 - l;
      end
      rank = l * 16 + sl;
      if (act && rank > best) begin
        best = rank; lvl = l; vec = v;
      end
    end
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend = '0; m_lvl = 0; m_vec = 0; m_cap = 0; m_req = 1'b0;
    end else begin
      int nl, nv;
      model_arb(periph_req_i, ext_irq_i, m_pend, nl, nv);
      if (ack_i && m_req) m_cap = m_vec;
      m_pend = (m_pend & ~swi_clr_i) | swi_set_i;
      m_lvl = nl; m_vec = nv; m_req = (nl != 0);
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // compare against the model every clock, away from the edge
  always @(negedge clk_i) begin
    if (cmp_en && !done) begin
      chk(irq_level_o, m_lvl, "R2 level vs model");
      chk(irq_req_o, m_req, "R2 request vs model");
      chk(vec_num_o, m_cap, "R9 captured vector vs model");
      chk(vec_off_o, m_cap * 4, "R6 offset vs model");
      chk(swi_pend_o, m_pend, "R8 pending vs model");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic ack_once();
    ack_i = 1'b1; step(1); ack_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    // R1: reset values
    chk(irq_level_o, 0, "R1 level"); chk(irq_req_o, 0, "R1 req");
    chk(vec_num_o, 0, "R1 vec"); chk(vec_off_o, 0, "R1 off"); chk(swi_pend_o, 0, "R1 pend");
    rst_ni = 1'b1; cmp_en = 1'b1;
    step(1);
    chk(irq_level_o, 0, "R1 level after release");

    // R4: level 3 slot 0 alone
    periph_req_i[16] = 1'b1; step(1);
    chk(irq_level_o, 3, "R2 level 3 one cycle later"); chk(irq_req_o, 1, "R2 req");
    ack_once();
    chk(vec_num_o, 75, "R4 level 3 slot 0 vector"); chk(vec_off_o, 300, "R6 offset");

    // R3: slot 8 of level 3 outranks slot 0 and the pin in slot 4
    periph_req_i[23] = 1'b1; ext_irq_i[2] = 1'b1; step(1);
    ack_once();
    chk(vec_num_o, 67, "R3 highest slot wins");
    ext_irq_i[2] = 1'b0; periph_req_i[23] = 1'b0; step(1);
    ack_once();
    chk(vec_num_o, 75, "R3 lower slot after drop");

    // R2: level 5 beats level 3
    periph_req_i[32] = 1'b1; step(1);
    chk(irq_level_o, 5, "R2 higher level wins");
    ack_once();
    chk(vec_num_o, 57, "R4 level 5 slot 0 vector");

    // R10: drop all lines
    periph_req_i = '0; step(1);
    chk(irq_level_o, 0, "R10 level after drop"); chk(irq_req_o, 0, "R10 req after drop");
    chk(vec_num_o, 57, "R9 held without ack");
    ack_once();
    chk(vec_num_o, 57, "R9 ack with no request ignored");

    // R5 / R8: software level 2
    swi_set_i = 7'b0000010; step(1); swi_set_i = '0;
    chk(swi_pend_o, 7'b0000010, "R8 set visible next clock");
    chk(irq_level_o, 0, "R8 not yet arbitrated");
    step(1);
    chk(irq_level_o, 2, "R8 software level 2 arbitrated");
    ack_once();
    chk(vec_num_o, 101, "R5 level 2 software vector"); chk(vec_off_o, 404, "R6 offset 404");

    // R7: pin and software share slot 4
    ext_irq_i[1] = 1'b1; step(1);
    ack_once();
    chk(vec_num_o, 80, "R7 pin beats software in slot 4");
    ext_irq_i[1] = 1'b0; step(1);
    ack_once();
    chk(vec_num_o, 101, "R10 software again after pin drops");

    // R5: level 1 software, clear level 2
    swi_set_i = 7'b0000001; swi_clr_i = 7'b0000010; step(1);
    swi_set_i = '0; swi_clr_i = '0; step(1);
    chk(irq_level_o, 1, "R8 clear removes level 2");
    ack_once();
    chk(vec_num_o, 102, "R5 level 1 software vector");

    // R8: set and clear together on level 7
    swi_set_i = 7'b1000000; swi_clr_i = 7'b1000000; step(1);
    swi_set_i = '0; swi_clr_i = '0;
    chk(swi_pend_o, 7'b1000001, "R8 set wins over clear");
    step(1);
    chk(irq_level_o, 7, "R2 level 7");
    ack_once();
    chk(vec_num_o, 96, "R5 level 7 software vector");
    step(3);
    chk(swi_pend_o, 7'b1000001, "R8 stays pending");
    swi_clr_i = 7'b1000001; step(1); swi_clr_i = '0; step(1);
    chk(irq_level_o, 0, "R8 cleared, idle");

    // mixed traffic against the model
    for (int c = 0; c < 3000; c++) begin
      for (int b = 0; b < 56; b++) periph_req_i[b] = ($urandom_range(0, 31) == 0);
      for (int b = 0; b < 7; b++) begin
        ext_irq_i[b] = ($urandom_range(0, 15) == 0);
        swi_set_i[b] = ($urandom_range(0, 23) == 0);
        swi_clr_i[b] = ($urandom_range(0, 11) == 0);
      end
      ack_i = ($urandom_range(0, 2) == 0);
      step(1);
      checks++;
      if (!(vec_num_o == 0 || (vec_num_o >= 31 && vec_num_o <= 93) ||
            (vec_num_o >= 96 && vec_num_o <= 102))) begin
        fails++;
        $display("FAIL R11 reserved vector: actual %0d expected non-reserved", vec_num_o);
      end
    end
    periph_req_i = '0; ext_irq_i = '0; swi_set_i = '0; swi_clr_i = '0; ack_i = 1'b0;
    step(2);
    finish_run();
  end
endmodule